// File: doc/BRIEF.md
# Sixteen-Pin GPIO Controller with Edge Interrupts

This block gives a processor sixteen general-purpose pins behind a small 16-bit register interface. Each pin can be an input or an output. Output pins take their level from an output latch. Input pins are resynchronised and watched for edges. A rising or falling edge, picked per pin, can set a sticky status bit and raise one shared interrupt line. The line stays high until software writes the status register.

Software reaches the block through a simple single-cycle access port. A strobe marks the access, a flag marks it as a write, and a size code gives its width. Any width other than 16 bits is refused. The drive lines move on the clock edge that accepts a write to the output latch or to the direction register. A direction change re-drives, in that same write, every affected pin whose latch holds 1.

Top module: `gpio16_ctrl`

## Requirements
- R1: After reset the drive lines and the interrupt are 0. Reads return direction 0xFFFF (all inputs, 1 = input), mask 0xFFFF (1 = masked), edge select 0x0000, status 0x0000 and pin enable 0xFFFF.
- R2: A read of the input register (offset 0x00) returns the synchronised pin levels ANDed with the pin-enable register (offset 0x18). A pin change shows in this read after two rising clock edges.
- R3: A write to the output latch (offset 0x04) stores the full value. The drive line of a pin takes the new latch bit only where that pin's direction bit is 0. Drive lines of input pins keep their value.
- R4: A write to the direction register (offset 0x08) re-drives each pin whose direction bit changes and whose latch bit is 1. Such a pin drives 1 if it became an output and 0 if it became an input. No other drive line moves.
- R5: The edge-select register (offset 0x0C) picks the edge per pin: bit 1 means rising and bit 0 means falling. A qualifying edge sets that pin's status bit (offset 0x14) and the interrupt. Both are visible after the third rising clock edge that follows the pin change. An edge of the other polarity does nothing.
- R6: An edge qualifies only when the pin's direction bit is 1 and its mask bit (offset 0x10) is 0.
- R7: Any accepted write to the status register drops the interrupt on the next edge. The status bits written as 1 are cleared and the others are kept.
- R8: When a qualifying edge and a status write fall in the same cycle, the new status bit is set and the interrupt stays asserted.
- R9: Only accesses with size code 2'b01 (16 bits) are accepted. A write of any other size changes nothing, and a read of any other size returns 0.
- R10: Writes to the input register have no effect. Reads of an unused offset return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_en | input | 1 | Access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_size | input | 2 | Access width code, 2'b01 = 16 bits |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational, 0 when not a valid read |
| pad_in | input | 16 | Asynchronous pin levels |
| pad_drive | output | 16 | Pin drive levels |
| irq | output | 1 | Interrupt, high until a status write |

## Verification
An edge on a pin and a software write to the status register can land in the same clock cycle. The write tries to drop the interrupt and clear bits, while the edge tries to set them. The bench times a falling edge on one pin so that its detection lands on the cycle that takes a status write of all ones. It then expects the interrupt still high and exactly that pin's status bit left set, with the older bit gone.

// File: rtl/gpio16_pkg.sv
package gpio16_pkg;

  localparam int unsigned ADDR_W = 8;

  typedef enum logic [ADDR_W-1:0] {
    OFS_DIN  = 8'h00,
    OFS_DOUT = 8'h04,
    OFS_DIR  = 8'h08,
    OFS_EDGE = 8'h0C,
    OFS_MASK = 8'h10,
    OFS_STAT = 8'h14,
    OFS_PEN  = 8'h18
  } reg_ofs_e;

  localparam logic [1:0] SZ_HALF = 2'b01;

endpackage

// File: rtl/gpio16_sync.sv
module gpio16_sync #(
  parameter int unsigned WIDTH  = 16,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);

  logic [WIDTH-1:0] stage_q [STAGES];
  logic [WIDTH-1:0] stage_d [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      assign stage_d[s] = async_in;
    end else begin : g_next
      assign stage_d[s] = stage_q[s-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= '0;
      else        stage_q[s] <= stage_d[s];
    end
  end

  assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/gpio16_edge.sv
module gpio16_edge #(
  parameter int unsigned WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] level,
  input  logic [WIDTH-1:0] rise_sel,
  input  logic [WIDTH-1:0] is_input,
  input  logic [WIDTH-1:0] masked,
  output logic [WIDTH-1:0] hit
);

  logic [WIDTH-1:0] prev_q;
  logic [WIDTH-1:0] rose;
  logic [WIDTH-1:0] fell;

  always_comb begin
    rose = level & ~prev_q;
    fell = ~level & prev_q;
    hit  = ((rise_sel & rose) | (~rise_sel & fell)) & is_input & ~masked;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= level;
  end

  // R6: no edge may qualify on a masked pin or on an output pin
  a_r6_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (hit & (masked | ~is_input)) == '0);

endmodule

// File: rtl/gpio16_regs.sv
module gpio16_regs
  import gpio16_pkg::*;
#(
  parameter int unsigned WIDTH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_en,
  input  logic              acc_wr,
  input  logic [1:0]        acc_size,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [WIDTH-1:0]  acc_wdata,
  output logic [WIDTH-1:0]  acc_rdata,
  input  logic [WIDTH-1:0]  level,
  input  logic [WIDTH-1:0]  hit,
  output logic [WIDTH-1:0]  dir_q,
  output logic [WIDTH-1:0]  edge_q,
  output logic [WIDTH-1:0]  mask_q,
  output logic [WIDTH-1:0]  drive_q,
  output logic              irq_q
);

  logic [WIDTH-1:0] latch_q, latch_d;
  logic [WIDTH-1:0] dir_d, edge_d, mask_d;
  logic [WIDTH-1:0] stat_q, stat_d;
  logic [WIDTH-1:0] pen_q, pen_d;
  logic [WIDTH-1:0] drive_d;
  logic [WIDTH-1:0] redrive;
  logic             irq_d;
  logic             size_ok, wr_ok, rd_ok;
  logic             wr_dout, wr_dir, wr_edge, wr_mask, wr_stat, wr_pen;

  always_comb begin
    size_ok = (acc_size == SZ_HALF);
    wr_ok   = acc_en & acc_wr & size_ok;
    rd_ok   = acc_en & ~acc_wr & size_ok;
    wr_dout = wr_ok & (acc_addr == OFS_DOUT);
    wr_dir  = wr_ok & (acc_addr == OFS_DIR);
    wr_edge = wr_ok & (acc_addr == OFS_EDGE);
    wr_mask = wr_ok & (acc_addr == OFS_MASK);
    wr_stat = wr_ok & (acc_addr == OFS_STAT);
    wr_pen  = wr_ok & (acc_addr == OFS_PEN);
  end

  always_comb begin
    latch_d = wr_dout ? acc_wdata : latch_q;
    dir_d   = wr_dir  ? acc_wdata : dir_q;
    edge_d  = wr_edge ? acc_wdata : edge_q;
    mask_d  = wr_mask ? acc_wdata : mask_q;
    pen_d   = wr_pen  ? acc_wdata : pen_q;

    redrive = latch_q & (dir_q ^ acc_wdata);
    drive_d = drive_q;
    if (wr_dout) drive_d = (drive_q & dir_q) | (acc_wdata & ~dir_q);
    if (wr_dir)  drive_d = (drive_q & ~redrive) | (latch_q & ~acc_wdata & redrive);

    stat_d = wr_stat ? (stat_q & ~acc_wdata) : stat_q;
    stat_d = stat_d | hit;

    irq_d = irq_q;
    if (wr_stat) irq_d = 1'b0;
    if (|hit)    irq_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= '0;
      dir_q   <= '1;
      edge_q  <= '0;
      mask_q  <= '1;
      stat_q  <= '0;
      pen_q   <= '1;
      drive_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      latch_q <= latch_d;
      dir_q   <= dir_d;
      edge_q  <= edge_d;
      mask_q  <= mask_d;
      stat_q  <= stat_d;
      pen_q   <= pen_d;
      drive_q <= drive_d;
      irq_q   <= irq_d;
    end
  end

  always_comb begin
    acc_rdata = '0;
    if (rd_ok) begin
      unique case (acc_addr)
        OFS_DIN:  acc_rdata = level & pen_q;
        OFS_DOUT: acc_rdata = latch_q;
        OFS_DIR:  acc_rdata = dir_q;
        OFS_EDGE: acc_rdata = edge_q;
        OFS_MASK: acc_rdata = mask_q;
        OFS_STAT: acc_rdata = stat_q;
        OFS_PEN:  acc_rdata = pen_q;
        default:  acc_rdata = '0;
      endcase
    end
  end

  // R7: a status write with no edge present drops the interrupt
  a_r7_irq_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && !(|hit)) |=> !irq_q);

  // R8: a qualifying edge always leaves the interrupt high
  a_r8_edge_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (|hit) |=> irq_q);

  // R3: a latch write never moves the drive of an input pin
  a_r3_input_drive_held: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dout |=> ((drive_q ^ $past(drive_q)) & $past(dir_q)) == '0);

  // R9: writes of a refused width leave the configuration alone
  a_r9_bad_width: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && acc_wr && acc_size != SZ_HALF) |=>
      ($stable(latch_q) && $stable(dir_q) && $stable(edge_q) &&
       $stable(mask_q) && $stable(pen_q) && $stable(drive_q)));

  // R5: status bits are sticky unless a status write clears them
  a_r5_stat_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stat |=> ((~stat_q & $past(stat_q)) == '0));

endmodule

// File: rtl/gpio16_ctrl.sv
module gpio16_ctrl
  import gpio16_pkg::*;
#(
  parameter int unsigned NPINS       = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_wr,
  input  logic [1:0]        bus_size,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [NPINS-1:0]  bus_wdata,
  output logic [NPINS-1:0]  bus_rdata,
  input  logic [NPINS-1:0]  pad_in,
  output logic [NPINS-1:0]  pad_drive,
  output logic              irq
);

  logic [1:0]       rst_pipe_q;
  logic             rst_int_n;
  logic [NPINS-1:0] level;
  logic [NPINS-1:0] hit;
  logic [NPINS-1:0] dir_w, edge_w, mask_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  gpio16_sync #(.WIDTH(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .async_in (pad_in),
    .sync_out (level)
  );

  gpio16_edge #(.WIDTH(NPINS)) u_edge (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .level    (level),
    .rise_sel (edge_w),
    .is_input (dir_w),
    .masked   (mask_w),
    .hit      (hit)
  );

  gpio16_regs #(.WIDTH(NPINS)) u_regs (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .acc_en    (bus_en),
    .acc_wr    (bus_wr),
    .acc_size  (bus_size),
    .acc_addr  (bus_addr),
    .acc_wdata (bus_wdata),
    .acc_rdata (bus_rdata),
    .level     (level),
    .hit       (hit),
    .dir_q     (dir_w),
    .edge_q    (edge_w),
    .mask_q    (mask_w),
    .drive_q   (pad_drive),
    .irq_q     (irq)
  );

  // R1: while reset is held the outputs stay quiet
  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_int_n |-> (!irq && pad_drive == '0));

endmodule

// File: tb/test_gpio16_ctrl.sv
`timescale 1ns/1ps
module test_gpio16_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_en = 1'b0;
  logic        bus_wr = 1'b0;
  logic [1:0]  bus_size = 2'b01;
  logic [7:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [15:0] pad_in = '0;
  logic [15:0] pad_drive;
  logic        irq;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  gpio16_ctrl i_gpio16_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_wr(bus_wr),
    .bus_size(bus_size), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .pad_in(pad_in), .pad_drive(pad_drive), .irq(irq)
  );

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [15:0] d, logic [1:0] sz = 2'b01);
    @(negedge clk);
    bus_en = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_size = sz;
    @(negedge clk);
    bus_en = 1'b0; bus_wr = 1'b0; bus_size = 2'b01;
  endtask

  task automatic rd(logic [7:0] a, output logic [15:0] d, input logic [1:0] sz = 2'b01);
    @(negedge clk);
    bus_en = 1'b1; bus_wr = 1'b0; bus_addr = a; bus_size = sz;
    #1 d = bus_rdata;
    bus_en = 1'b0; bus_size = 2'b01;
  endtask

  task automatic settle();
    repeat (4) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [15:0] v;
    check("R1 drive", pad_drive, 16'h0000);
    check("R1 irq", {15'd0, irq}, 16'h0000);
    rd(8'h08, v); check("R1 dir", v, 16'hFFFF);
    rd(8'h10, v); check("R1 mask", v, 16'hFFFF);
    rd(8'h0C, v); check("R1 edge", v, 16'h0000);
    rd(8'h14, v); check("R1 status", v, 16'h0000);
    rd(8'h18, v); check("R1 pin enable", v, 16'hFFFF);
  endtask

  task automatic t_dout();
    logic [15:0] v;
    wr(8'h04, 16'h00F0);
    check("R3 all inputs no drive", pad_drive, 16'h0000);
    wr(8'h08, 16'hFF00);
    check("R4 low byte to outputs", pad_drive, 16'h00F0);
    wr(8'h04, 16'h0F0F);
    check("R3 only outputs driven", pad_drive, 16'h000F);
    rd(8'h04, v); check("R3 latch readback", v, 16'h0F0F);
    wr(8'h08, 16'hFFFF);
    check("R4 back to inputs", pad_drive, 16'h0000);
  endtask

  task automatic t_dir();
    wr(8'h04, 16'h00F0);
    check("R3 latch write on inputs", pad_drive, 16'h0000);
    wr(8'h08, 16'hFF3F);
    check("R4 pins 6 7 become outputs", pad_drive, 16'h00C0);
    wr(8'h08, 16'hFFFF);
    check("R4 pins 6 7 become inputs", pad_drive, 16'h0000);
  endtask

  task automatic t_input();
    logic [15:0] v;
    wr(8'h18, 16'h00FF);
    @(negedge clk); pad_in = 16'hA5A5;
    @(posedge clk);
    rd(8'h00, v); check("R2 not yet visible", v, 16'h0000);
    @(posedge clk);
    rd(8'h00, v); check("R2 gated by pin enable", v, 16'h00A5);
    wr(8'h18, 16'hFFFF);
    rd(8'h00, v); check("R2 full read", v, 16'hA5A5);
    pad_in = 16'h0000;
    settle();
    check("R6 masked pins no irq", {15'd0, irq}, 16'h0000);
  endtask

  task automatic t_rise();
    logic [15:0] v;
    wr(8'h0C, 16'h0008);
    wr(8'h10, 16'hFFF7);
    @(negedge clk); pad_in[3] = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R5 irq not before third edge", {15'd0, irq}, 16'h0000);
    @(posedge clk); @(negedge clk);
    check("R5 rising edge irq", {15'd0, irq}, 16'h0001);
    rd(8'h14, v); check("R5 status pin 3", v, 16'h0008);
    wr(8'h14, 16'h0008);
    check("R7 irq dropped", {15'd0, irq}, 16'h0000);
    rd(8'h14, v); check("R7 status cleared", v, 16'h0000);
    pad_in[3] = 1'b0;
    settle();
    check("R5 falling ignored on rising pin", {15'd0, irq}, 16'h0000);
  endtask

  task automatic t_fall();
    logic [15:0] v;
    wr(8'h10, 16'hFFDF);
    pad_in[5] = 1'b1;
    settle();
    check("R5 rising ignored on falling pin", {15'd0, irq}, 16'h0000);
    pad_in[5] = 1'b0;
    settle();
    check("R5 falling edge irq", {15'd0, irq}, 16'h0001);
    rd(8'h14, v); check("R5 status pin 5", v, 16'h0020);
    wr(8'h14, 16'hFFFF);
  endtask

  task automatic t_gating();
    logic [15:0] v;
    wr(8'h08, 16'hFDFF);
    wr(8'h10, 16'hFDFF);
    pad_in[9] = 1'b1; settle();
    pad_in[9] = 1'b0; settle();
    check("R6 output pin no irq", {15'd0, irq}, 16'h0000);
    wr(8'h08, 16'hFFFF);
    wr(8'h10, 16'hFFFF);
    pad_in[9] = 1'b1; settle();
    pad_in[9] = 1'b0; settle();
    check("R6 masked pin no irq", {15'd0, irq}, 16'h0000);
    rd(8'h14, v); check("R6 status empty", v, 16'h0000);
  endtask

  task automatic t_clear();
    logic [15:0] v;
    wr(8'h10, 16'hFFD7);
    pad_in[5] = 1'b1; settle();
    pad_in[3] = 1'b1; pad_in[5] = 1'b0; settle();
    rd(8'h14, v); check("R7 two bits set", v, 16'h0028);
    wr(8'h14, 16'h0008);
    check("R7 any write drops irq", {15'd0, irq}, 16'h0000);
    rd(8'h14, v); check("R7 write one clears", v, 16'h0020);
    wr(8'h14, 16'h0020);
    rd(8'h14, v); check("R7 all cleared", v, 16'h0000);
  endtask

  task automatic t_collide();
    logic [15:0] v;
    pad_in[5] = 1'b1; pad_in[3] = 1'b0; settle();
    pad_in[3] = 1'b1; settle();
    rd(8'h14, v); check("R8 setup status", v, 16'h0008);
    @(negedge clk); pad_in[5] = 1'b0;
    repeat (2) @(posedge clk);
    wr(8'h14, 16'hFFFF);
    check("R8 edge beats status write irq", {15'd0, irq}, 16'h0001);
    rd(8'h14, v); check("R8 new bit kept old cleared", v, 16'h0020);
  endtask

  task automatic t_width();
    logic [15:0] v;
    wr(8'h14, 16'hFFFF, 2'b10);
    check("R9 wide status write ignored", {15'd0, irq}, 16'h0001);
    wr(8'h04, 16'hFFFF, 2'b10);
    wr(8'h08, 16'h0000, 2'b00);
    check("R9 no drive change", pad_drive, 16'h0000);
    rd(8'h04, v); check("R9 latch unchanged", v, 16'h00F0);
    rd(8'h08, v); check("R9 direction unchanged", v, 16'hFFFF);
    rd(8'h04, v, 2'b00); check("R9 byte read is zero", v, 16'h0000);
    wr(8'h14, 16'hFFFF);
  endtask

  task automatic t_readonly();
    logic [15:0] v;
    wr(8'h00, 16'h1234);
    rd(8'h18, v); check("R10 pin enable intact", v, 16'hFFFF);
    rd(8'h00, v); check("R10 input read intact", v, 16'h0008);
    rd(8'h1C, v); check("R10 unused offset", v, 16'h0000);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    t_reset();
    t_dout();
    t_dir();
    t_input();
    t_rise();
    t_fall();
    t_gating();
    t_clear();
    t_collide();
    t_width();
    t_readonly();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=%h expected=%h", 16'h0, 16'h1);
      end
    join_any
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule